// File: doc/BRIEF.md
# Double-High Scan Line Remapper

This block sits between a text display's scan-line counter and its character generator. The counter steps through the scan lines of one character row. The block turns that count into the glyph line address that the character generator reads. In single-high mode the address follows the count directly. In double-high mode each glyph line is repeated on two consecutive scan lines, so one text row shows only half of a glyph.

A half-select input picks which half is shown. With the top half selected, the row shows glyph lines 0 to 4. With the bottom half selected, it shows lines 5 to 9. A complete double-high character therefore takes two consecutive text rows: one row is driven with the top half and the next row with the bottom half.

The block also produces an underline strobe. The strobe is decoded from the remapped glyph line, not from the raw count, so the underline always falls on the same glyph line whatever the mode. Both outputs are registered and update once per clock. A count outside the row is ignored, and the outputs keep their last valid values.

Top module: `dhr_scan_remap`

## Requirements
- R1: While `rst` is high at a clock edge, `glyph_line` becomes 0 and `underline_stb` becomes 0.
- R2: With `dbl_high_en` = 0 and a valid `scan_cnt` (0 to 9), `glyph_line` equals that `scan_cnt` one clock later, and `bottom_sel` has no effect.
- R3: With `dbl_high_en` = 1, `bottom_sel` = 0 and a valid `scan_cnt`, `glyph_line` equals floor(`scan_cnt`/2) one clock later. This covers lines 0 to 4 across the ten scan lines.
- R4: With `dbl_high_en` = 1, `bottom_sel` = 1 and a valid `scan_cnt`, `glyph_line` equals floor(`scan_cnt`/2) + 5 one clock later. This covers lines 5 to 9 across the ten scan lines.
- R5: `underline_stb` is 1 exactly when the registered `glyph_line` is 8. This happens at scan count 8 in single-high mode and at scan counts 6 and 7 for the bottom half. It never happens for the top half.
- R6: When `scan_cnt` is above 9, both outputs keep their previous values on the next clock.
- R7: A change of `dbl_high_en` or `bottom_sel` takes effect on the outputs one clock after it is sampled, with no extra delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| scan_cnt | input | 4 | Raw scan line count within the character row (valid values 0 to 9) |
| dbl_high_en | input | 1 | 1 selects double-high line mapping |
| bottom_sel | input | 1 | In double-high mode, 1 shows the bottom half of the glyph and 0 shows the top half |
| glyph_line | output | 4 | Registered glyph line address for the character generator |
| underline_stb | output | 1 | Registered strobe, high when the glyph line is the underline line |

## Verification
Any error in the mode decode, the halving or the bottom-half offset shows at `glyph_line` on the very next clock edge after the scan count that triggers it. The bench therefore sweeps every count in every mode and compares on every clock.

An error in the validity check would make the output move on a count of 10 to 15, where it must stay still. Such an error is visible one clock after the out-of-range count.

A fault in the underline decode appears as a strobe on the wrong line or as a missing strobe in the same cycle as the glyph line it belongs to. Random sequences that mix modes and invalid counts also expose any hold that fails to cover both outputs together.

// File: rtl/dhr_pkg.sv
package dhr_pkg;

    localparam int unsigned DEF_ROW_LINES = 10;
    localparam int unsigned DEF_UL_LINE   = 8;

    typedef enum logic [1:0] {
        MAP_SINGLE  = 2'd0,
        MAP_DBL_TOP = 2'd1,
        MAP_DBL_BOT = 2'd2
    } map_mode_e;

    // Pick the line mapping from the two mode inputs.
    function automatic map_mode_e decode_mode(input logic dbl_en, input logic bot);
        if (!dbl_en)
            return MAP_SINGLE;
        else if (bot)
            return MAP_DBL_BOT;
        else
            return MAP_DBL_TOP;
    endfunction

endpackage

// File: rtl/dhr_scan_check.sv
module dhr_scan_check #(
    parameter int unsigned ROW_LINES = dhr_pkg::DEF_ROW_LINES,
    localparam int unsigned LINE_W   = $clog2(ROW_LINES)
) (
    input  logic [LINE_W-1:0] scan_cnt,
    output logic              scan_ok
);
    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(ROW_LINES - 1);

    always_comb scan_ok = (scan_cnt <= LAST_LINE);
endmodule

// File: rtl/dhr_line_map.sv
module dhr_line_map #(
    parameter int unsigned ROW_LINES = dhr_pkg::DEF_ROW_LINES,
    localparam int unsigned LINE_W   = $clog2(ROW_LINES)
) (
    input  dhr_pkg::map_mode_e  mode,
    input  logic [LINE_W-1:0]   scan_cnt,
    output logic [LINE_W-1:0]   mapped_line
);
    import dhr_pkg::*;

    localparam logic [LINE_W-1:0] HALF_OFS = LINE_W'(ROW_LINES / 2);

    logic [LINE_W-1:0] halved;

    always_comb halved = scan_cnt >> 1;

    always_comb begin
        unique case (mode)
            MAP_DBL_TOP: mapped_line = halved;
            MAP_DBL_BOT: mapped_line = halved + HALF_OFS;
            default:     mapped_line = scan_cnt;
        endcase
    end
endmodule

// File: rtl/dhr_out_reg.sv
module dhr_out_reg #(
    parameter int unsigned ROW_LINES = dhr_pkg::DEF_ROW_LINES,
    parameter int unsigned UL_LINE   = dhr_pkg::DEF_UL_LINE,
    localparam int unsigned LINE_W   = $clog2(ROW_LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [LINE_W-1:0] next_line,
    output logic [LINE_W-1:0] line_q,
    output logic              ul_q
);
    localparam logic [LINE_W-1:0] UL_CODE = LINE_W'(UL_LINE);

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
            ul_q   <= 1'b0;
        end else if (load) begin
            line_q <= next_line;
            ul_q   <= (next_line == UL_CODE);
        end
    end
endmodule

// File: rtl/dhr_scan_remap.sv
module dhr_scan_remap #(
    parameter int unsigned ROW_LINES = dhr_pkg::DEF_ROW_LINES,
    parameter int unsigned UL_LINE   = dhr_pkg::DEF_UL_LINE,
    localparam int unsigned LINE_W   = $clog2(ROW_LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_W-1:0] scan_cnt,
    input  logic              dbl_high_en,
    input  logic              bottom_sel,
    output logic [LINE_W-1:0] glyph_line,
    output logic              underline_stb
);
    import dhr_pkg::*;

    map_mode_e         mode;
    logic              scan_ok;
    logic [LINE_W-1:0] mapped_line;

    always_comb mode = decode_mode(dbl_high_en, bottom_sel);

    dhr_scan_check #(.ROW_LINES(ROW_LINES)) u_check (
        .scan_cnt (scan_cnt),
        .scan_ok  (scan_ok)
    );

    dhr_line_map #(.ROW_LINES(ROW_LINES)) u_map (
        .mode        (mode),
        .scan_cnt    (scan_cnt),
        .mapped_line (mapped_line)
    );

    dhr_out_reg #(.ROW_LINES(ROW_LINES), .UL_LINE(UL_LINE)) u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (scan_ok),
        .next_line (mapped_line),
        .line_q    (glyph_line),
        .ul_q      (underline_stb)
    );
endmodule

// File: rtl/dhr_scan_remap_chk.sv
module dhr_scan_remap_chk #(
    parameter int unsigned ROW_LINES = dhr_pkg::DEF_ROW_LINES,
    parameter int unsigned UL_LINE   = dhr_pkg::DEF_UL_LINE,
    localparam int unsigned LINE_W   = $clog2(ROW_LINES)
) (
    input logic              clk,
    input logic              rst,
    input logic [LINE_W-1:0] scan_cnt,
    input logic              dbl_high_en,
    input logic              bottom_sel,
    input logic [LINE_W-1:0] glyph_line,
    input logic              underline_stb
);
    localparam logic [LINE_W-1:0] LAST = LINE_W'(ROW_LINES - 1);
    localparam logic [LINE_W-1:0] HALF = LINE_W'(ROW_LINES / 2);
    localparam logic [LINE_W-1:0] ULC  = LINE_W'(UL_LINE);

    // R1: reset clears both outputs
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (glyph_line == '0 && !underline_stb));

    // R2: single-high passes the count through
    p_single_pass_r2: assert property (@(posedge clk) disable iff (rst)
        (scan_cnt <= LAST && !dbl_high_en) |=> glyph_line == $past(scan_cnt));

    // R3: top half stays in the lower half of the glyph
    p_top_range_r3: assert property (@(posedge clk) disable iff (rst)
        (scan_cnt <= LAST && dbl_high_en && !bottom_sel) |=> glyph_line < HALF);

    // R4: bottom half stays in the upper half of the glyph
    p_bot_range_r4: assert property (@(posedge clk) disable iff (rst)
        (scan_cnt <= LAST && dbl_high_en && bottom_sel)
        |=> (glyph_line >= HALF && glyph_line <= LAST));

    // R5: the strobe tracks the underline line
    p_ul_match_r5: assert property (@(posedge clk) disable iff (rst)
        underline_stb == (glyph_line == ULC));

    // R6: an out-of-range count freezes both outputs
    p_hold_invalid_r6: assert property (@(posedge clk) disable iff (rst)
        (scan_cnt > LAST) |=> ($stable(glyph_line) && $stable(underline_stb)));
endmodule

bind dhr_scan_remap dhr_scan_remap_chk #(.ROW_LINES(ROW_LINES), .UL_LINE(UL_LINE)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .scan_cnt      (scan_cnt),
    .dbl_high_en   (dbl_high_en),
    .bottom_sel    (bottom_sel),
    .glyph_line    (glyph_line),
    .underline_stb (underline_stb)
);

// File: tb/test_dhr_scan_remap.sv
`timescale 1ns/1ps
module test_dhr_scan_remap;
    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] scan_cnt;
    logic       dbl_high_en;
    logic       bottom_sel;
    logic [3:0] glyph_line;
    logic       underline_stb;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_line = 0;
    int exp_ul = 0;
    string exp_tag = "R1";
    int hist[$];

    always #2.5 clk = ~clk;

    dhr_scan_remap i_dhr_scan_remap (
        .clk           (clk),
        .rst           (rst),
        .scan_cnt      (scan_cnt),
        .dbl_high_en   (dbl_high_en),
        .bottom_sel    (bottom_sel),
        .glyph_line    (glyph_line),
        .underline_stb (underline_stb)
    );

    // Compare outputs with the model, then apply inputs and predict the next edge.
    task automatic step(input bit r, input int sc, input bit dbl, input bit bot);
        @(negedge clk);
        n_cmp++;
        if (int'(glyph_line) != exp_line) begin
            n_bad++;
            $display("FAIL %s glyph_line: actual %0d expected %0d", exp_tag, glyph_line, exp_line);
        end
        n_cmp++;
        if (int'(underline_stb) != exp_ul) begin
            n_bad++;
            $display("FAIL R5/%s underline_stb: actual %0d expected %0d", exp_tag, underline_stb, exp_ul);
        end
        rst = r; scan_cnt = 4'(sc); dbl_high_en = dbl; bottom_sel = bot;
        if (r) begin
            exp_line = 0; exp_ul = 0; exp_tag = "R1";
        end else if (sc > 9) begin
            exp_tag = "R6";
        end else begin
            if (!dbl) begin exp_line = sc; exp_tag = "R2"; end
            else if (!bot) begin exp_line = sc / 2; exp_tag = "R3"; end
            else begin exp_line = sc / 2 + 5; exp_tag = "R4"; end
            exp_ul = (exp_line == 8) ? 1 : 0;
        end
        hist.push_back(exp_line);
        if (hist.size() > 4) void'(hist.pop_front());
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; scan_cnt = '0; dbl_high_en = 1'b0; bottom_sel = 1'b0;
        // R1: reset state after a few reset cycles, with inputs nonzero
        step(1, 7, 1, 1);
        step(1, 8, 0, 0);
        step(1, 3, 1, 0);
        // R2, R3, R4, R6: full sweep of every count in every mode
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 16; s++) step(0, s, m[1], m[0]);
        end
        // R7: mode changes on consecutive clocks with a fixed count
        for (int k = 0; k < 12; k++) step(0, 7, k[0], k[1]);
        // R5: underline lines across modes
        step(0, 8, 0, 1);
        step(0, 6, 1, 1);
        step(0, 7, 1, 1);
        step(0, 8, 1, 0);
        // R6: invalid count right after an underline line must hold the strobe
        step(0, 8, 0, 0);
        step(0, 12, 1, 1);
        step(0, 15, 1, 0);
        // R1: reset mid-run
        step(1, 9, 1, 1);
        // Random mix including invalid counts and reset pulses
        for (int i = 0; i < 3000; i++) begin
            int r_sc;
            r_sc = int'($urandom_range(0, 15));
            step(($urandom_range(0, 99) == 0), r_sc, 1'($urandom), 1'($urandom));
        end
        step(0, 0, 0, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule